// File: doc/BRIEF.md
# CPU-Cycle Interrupt Down-Counter

This block is a 16-bit interrupt timer that counts processor clock cycles. Software loads the count with two byte-wide register writes, one for the low half and one for the high half. Once armed, the counter steps down by one on every cycle in which the processor cycle enable is high. When a step brings it to zero it reloads all ones and raises a level interrupt request. The request stays high until software writes the low byte again.

A third strobe writes a mode byte, of which only bit 7 is kept as the interrupt enable bit. A parameter selects one of two variants. In the one-shot variant, a high-byte write arms the counter only when the stored enable bit is 1, and expiry disarms it. In the free-running variant, a high-byte write always arms the counter. Expiry then sets the interrupt line to the stored enable bit, and the counter keeps running. Address decoding is done outside the block, which sees only the three strobes.

Top module: `cpu_cycle_irq_timer`

## Requirements
- R1: After reset the counter is zero, disarmed and `irq` is low, so processor cycles alone never raise `irq`.
- R2: A cycle with `wr_lo` high replaces bits 7:0 of the counter with `wr_data` and drives `irq` low from the next cycle.
- R3: A cycle with `wr_hi` high replaces bits 15:8 of the counter with `wr_data`. In the one-shot variant it sets the armed state to the stored enable bit. In the free-running variant it always arms. It never changes `irq`.
- R4: While armed, each cycle with `cpu_tick` high and no load lowers the counter by one. Cycles with `cpu_tick` low leave it unchanged.
- R5: When a decrement brings the counter to zero, the counter takes 0xFFFF instead. `irq` changes on the same clock edge, so a count of N fires after exactly N ticks.
- R6: One-shot variant: expiry sets `irq` high and disarms the counter, so further ticks raise no new interrupt.
- R7: Free-running variant: expiry sets `irq` to the stored enable bit and the counter stays armed, so the next expiry follows after 65535 further ticks.
- R8: `irq` is a level. Once high, it stays high until a low-byte write, or in the free-running variant until an expiry that occurs while the enable bit is 0.
- R9: When a byte load and a decrement fall in the same cycle, the load wins and no decrement takes place.
- R10: A cycle with `wr_mode` high stores `wr_data[7]` as the enable bit. The other bits of the mode byte are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_tick | input | 1 | One processor cycle elapsed |
| wr_lo | input | 1 | Write strobe for the counter low byte |
| wr_hi | input | 1 | Write strobe for the counter high byte |
| wr_mode | input | 1 | Write strobe for the mode byte (bit 7 is the enable bit) |
| wr_data | input | 8 | Write data shared by the three strobes |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds two copies side by side with the default 8-bit byte width, one with `VARIANT` set to one-shot and one set to free-running, and drives both with the same stimulus. Because both copies share that stimulus, every phase shows how the variants differ on disarming, arming from the enable bit and gating of the interrupt. The default 16-bit count keeps a full 65535-tick reload period short enough to run, so the bench checks the second expiry of the free-running copy and the silence of the disarmed one-shot copy cycle by cycle.

// File: rtl/cyc_timer_pkg.sv
// Shared definitions for the CPU-cycle interrupt timer.
// Assumes nothing beyond a standard 8-bit write bus.
package cyc_timer_pkg;
    typedef enum logic {
        TMR_ONE_SHOT = 1'b0,
        TMR_FREE_RUN = 1'b1
    } tmr_variant_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/cyc_timer_count.sv
// Counter datapath: byte-lane loads and the decrement with reload to all ones.
// It raises a one-cycle expire flag when a decrement would reach zero.
// Assumes that no more than one lane strobe is high in any cycle.
module cyc_timer_count #(
    parameter int DATA_W = 8,
    parameter int LANES  = 2,
    localparam int CNT_W = DATA_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              dec_en,
    output logic [CNT_W-1:0]  count,
    output logic              expire
);
    logic             any_wr;
    logic [CNT_W-1:0] loaded;
    logic [CNT_W-1:0] cnt_d;

    assign any_wr = |lane_wr;

    // Per-lane merge of the write data into the current count.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign loaded[g*DATA_W +: DATA_W] =
            lane_wr[g] ? wr_data : count[g*DATA_W +: DATA_W];
    end

    // Expiry: a decrement taken from a count of one.
    assign expire = dec_en && !any_wr && (count == CNT_W'(1));

    // Next count: a load has priority over a decrement.
    always_comb begin
        cnt_d = count;
        if (any_wr) begin
            cnt_d = loaded;
        end else if (dec_en) begin
            cnt_d = expire ? {CNT_W{1'b1}} : count - CNT_W'(1);
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= cnt_d;
        end
    end
endmodule

// File: rtl/cyc_timer_ctrl.sv
// Control: stored enable bit, armed flag and interrupt level.
// VARIANT selects whether expiry disarms, and whether arming or the
// interrupt is gated by the enable bit.
// Assumes that wr_lo and expire are never high together, which the datapath ensures.
module cyc_timer_ctrl
    import cyc_timer_pkg::*;
#(
    parameter tmr_variant_e VARIANT = TMR_ONE_SHOT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_lo,
    input  logic wr_hi,
    input  logic wr_mode,
    input  logic en_bit,
    input  logic expire,
    output logic armed,
    output logic irq
);
    logic en_q;

    // Enable bit captured from a mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (wr_mode) begin
            en_q <= en_bit;
        end
    end

    if (VARIANT == TMR_ONE_SHOT) begin : g_one_shot
        // Armed from the enable bit on a high-byte write; cleared on expiry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                armed <= 1'b0;
            end else if (wr_hi) begin
                armed <= en_q;
            end else if (expire) begin
                armed <= 1'b0;
            end
        end

        // Interrupt set on expiry, cleared by a low-byte write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq <= 1'b0;
            end else if (wr_lo) begin
                irq <= 1'b0;
            end else if (expire) begin
                irq <= 1'b1;
            end
        end
    end else begin : g_free_run
        // Any high-byte write arms; only reset disarms.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                armed <= 1'b0;
            end else if (wr_hi) begin
                armed <= 1'b1;
            end
        end

        // Interrupt follows the enable bit at expiry, cleared by a low-byte write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq <= 1'b0;
            end else if (wr_lo) begin
                irq <= 1'b0;
            end else if (expire) begin
                irq <= en_q;
            end
        end
    end
endmodule

// File: rtl/cpu_cycle_irq_timer.sv
// Top of the CPU-cycle interrupt timer: a counter loaded a byte at a time,
// armed by a high-byte write and stepped down by processor cycles.
// Assumes that address decoding upstream asserts at most one strobe per cycle.
module cpu_cycle_irq_timer
    import cyc_timer_pkg::*;
#(
    parameter tmr_variant_e VARIANT = TMR_ONE_SHOT,
    parameter int           DATA_W  = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_mode,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq
);
    localparam int LANES = 2;
    localparam int CNT_W = DATA_W * LANES;

    logic [CNT_W-1:0] cnt_val;
    logic             armed;
    logic             expire;
    logic             dec_en;

    assign dec_en = armed && cpu_tick;

    cyc_timer_count #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_wr ({wr_hi, wr_lo}),
        .wr_data (wr_data),
        .dec_en  (dec_en),
        .count   (cnt_val),
        .expire  (expire)
    );

    cyc_timer_ctrl #(
        .VARIANT (VARIANT)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_mode (wr_mode),
        .en_bit  (wr_data[DATA_W-1]),
        .expire  (expire),
        .armed   (armed),
        .irq     (irq)
    );
endmodule

// File: rtl/cyc_timer_chk.sv
// Property checker for the CPU-cycle interrupt timer, attached with bind.
// It watches the ports together with the internal count and armed state.
module cyc_timer_chk
    import cyc_timer_pkg::*;
#(
    parameter tmr_variant_e VARIANT = TMR_ONE_SHOT,
    parameter int           DATA_W  = 8,
    parameter int           CNT_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_tick,
    input logic              wr_lo,
    input logic              wr_hi,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq,
    input logic              armed,
    input logic [CNT_W-1:0]  cnt
);
    logic was_in_rst = 1'b0;
    logic step;
    logic last_step;

    // Records whether reset was applied on the previous edge.
    always_ff @(posedge clk) begin
        was_in_rst <= !rst_n;
    end

    assign step      = armed && cpu_tick && !wr_lo && !wr_hi;
    assign last_step = step && (cnt == CNT_W'(1));

    p_reset_state_r1: assert property (@(posedge clk)
        (was_in_rst && rst_n) |-> (!irq && !armed && cnt == '0));

    p_lo_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> !irq);

    p_lo_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cnt[DATA_W-1:0] == $past(wr_data)));

    p_hi_keeps_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && irq) |=> irq);

    p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt != CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(armed && cpu_tick) && !wr_lo && !wr_hi) |=> $stable(cnt));

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        last_step |=> (cnt == {CNT_W{1'b1}}));

    p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(wr_lo) ||
                        (VARIANT == TMR_FREE_RUN && $past(last_step))));

    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && armed && cpu_tick) |=> (cnt[CNT_W-1:DATA_W] == $past(cnt[CNT_W-1:DATA_W])));

    if (VARIANT == TMR_ONE_SHOT) begin : g_os
        p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
            last_step |=> (irq && !armed));
    end else begin : g_fr
        p_stays_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
            armed |=> armed);
    end
endmodule

bind cpu_cycle_irq_timer cyc_timer_chk #(
    .VARIANT (VARIANT),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_tick (cpu_tick),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wr_data  (wr_data),
    .irq      (irq),
    .armed    (armed),
    .cnt      (cnt_val)
);

// File: tb/tb_cpu_cycle_irq_timer.sv
// Bench: one-shot (dut) and free-running (dut_fr) copies under shared stimulus,
// each compared on every clock with a behavioural model.
module tb_cpu_cycle_irq_timer;
    import cyc_timer_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_tick = 1'b0;
    logic       wr_lo = 1'b0;
    logic       wr_hi = 1'b0;
    logic       wr_mode = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_os;
    logic       irq_fr;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Model state: index 0 is one-shot, index 1 is free-running.
    int m_cnt [2];
    bit m_arm [2];
    bit m_en  [2];
    bit m_irq [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_cycle_irq_timer #(.VARIANT(TMR_ONE_SHOT)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_lo(wr_lo),
        .wr_hi(wr_hi), .wr_mode(wr_mode), .wr_data(wr_data), .irq(irq_os));

    cpu_cycle_irq_timer #(.VARIANT(TMR_FREE_RUN)) dut_fr (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_lo(wr_lo),
        .wr_hi(wr_hi), .wr_mode(wr_mode), .wr_data(wr_data), .irq(irq_fr));

    // Behavioural model following the requirements.
    always @(posedge clk) begin
        for (int v = 0; v < 2; v++) begin
            if (!rst_n) begin
                m_cnt[v] = 0; m_arm[v] = 0; m_en[v] = 0; m_irq[v] = 0;
            end else begin
                bit old_en;
                old_en = m_en[v];
                if (wr_mode) m_en[v] = wr_data[7];
                if (wr_lo) begin
                    m_cnt[v] = (m_cnt[v] & 32'hFF00) | int'(wr_data);
                    m_irq[v] = 0;
                end else if (wr_hi) begin
                    m_cnt[v] = (m_cnt[v] & 32'h00FF) | (int'(wr_data) << 8);
                    m_arm[v] = (v == 1) ? 1'b1 : old_en;
                end else if (m_arm[v] && cpu_tick) begin
                    m_cnt[v] = (m_cnt[v] - 1) & 32'hFFFF;
                    if (m_cnt[v] == 0) begin
                        m_cnt[v] = 32'hFFFF;
                        if (v == 0) begin
                            m_irq[v] = 1; m_arm[v] = 0;
                        end else begin
                            m_irq[v] = old_en;
                        end
                    end
                end
            end
        end
    end

    // Per-cycle comparison of both copies with the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq_os !== m_irq[0] || irq_fr !== m_irq[1]) begin
                errors++;
                $display("FAIL %s model compare: one-shot irq %b exp %b, free irq %b exp %b",
                         cur_req, irq_os, m_irq[0], irq_fr, m_irq[1]);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: cycles %0d exp below %0d", cycles, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic got_os, input logic exp_os,
                       input logic got_fr, input logic exp_fr);
        checks++;
        if (got_os !== exp_os || got_fr !== exp_fr) begin
            errors++;
            $display("FAIL %s: one-shot irq %b exp %b, free irq %b exp %b",
                     req, got_os, exp_os, got_fr, exp_fr);
        end
    endtask

    task automatic idle(input int n, input logic tick);
        for (int i = 0; i < n; i++) begin
            cpu_tick = tick; wr_lo = 0; wr_hi = 0; wr_mode = 0;
            @(negedge clk);
        end
        cpu_tick = 0;
    endtask

    // kind: 0 = low byte, 1 = high byte, 2 = mode byte.
    task automatic wr(input int kind, input logic [7:0] d, input logic tick);
        wr_lo = (kind == 0); wr_hi = (kind == 1); wr_mode = (kind == 2);
        wr_data = d; cpu_tick = tick;
        @(negedge clk);
        wr_lo = 0; wr_hi = 0; wr_mode = 0; cpu_tick = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, ticks alone do nothing.
        cur_req = "R1";
        chk("R1 reset", irq_os, 0, irq_fr, 0);
        idle(10, 1);
        chk("R1 ticks after reset", irq_os, 0, irq_fr, 0);

        // R10/R5/R6/R7: mode 0x80 (only bit 7 kept), count 5, fires after 5 ticks.
        cur_req = "R5";
        wr(2, 8'hFF, 0);
        wr(0, 8'h05, 0);
        wr(1, 8'h00, 0);
        idle(4, 1);
        chk("R5 before expiry", irq_os, 0, irq_fr, 0);
        idle(1, 1);
        chk("R6 R10 expiry", irq_os, 1, irq_fr, 1);

        // R8: level held.
        cur_req = "R8";
        idle(20, 1);
        chk("R8 held", irq_os, 1, irq_fr, 1);

        // R2/R4: low write with tick clears; count 3 with gaps in ticks.
        cur_req = "R2";
        wr(0, 8'h03, 1);
        chk("R2 clear", irq_os, 0, irq_fr, 0);
        wr(1, 8'h00, 0);
        cur_req = "R4";
        idle(1, 1); idle(2, 0); idle(1, 1); idle(3, 0);
        chk("R4 two ticks", irq_os, 0, irq_fr, 0);
        idle(1, 1);
        chk("R4 third tick", irq_os, 1, irq_fr, 1);

        // R6/R7: counts at 0xFFFF; one-shot disarmed, free-running reloads.
        cur_req = "R7";
        wr(0, 8'hFF, 0);
        idle(65534, 1);
        chk("R7 before second expiry", irq_os, 0, irq_fr, 0);
        idle(1, 1);
        chk("R7 R6 second expiry", irq_os, 0, irq_fr, 1);

        // R3/R7: enable 0, high write keeps irq, free expiry drives irq low.
        cur_req = "R3";
        wr(2, 8'h7F, 0);
        wr(1, 8'h00, 0);
        chk("R3 high write keeps irq", irq_os, 0, irq_fr, 1);
        idle(254, 1);
        chk("R7 before gated expiry", irq_os, 0, irq_fr, 1);
        idle(1, 1);
        chk("R7 expiry with enable 0", irq_os, 0, irq_fr, 0);
        idle(300, 1);
        chk("R3 one-shot not armed", irq_os, 0, irq_fr, 0);

        // R9: load wins over decrement.
        cur_req = "R9";
        wr(2, 8'h80, 0);
        wr(0, 8'h02, 0);
        wr(1, 8'h00, 0);
        wr(0, 8'h02, 1);
        idle(1, 1);
        chk("R9 low load wins", irq_os, 0, irq_fr, 0);
        idle(1, 1);
        chk("R9 fire after 2", irq_os, 1, irq_fr, 1);
        wr(0, 8'h02, 0);
        wr(1, 8'h00, 1);
        idle(1, 1);
        chk("R9 high load wins", irq_os, 0, irq_fr, 0);
        idle(1, 1);
        chk("R9 fire after high load", irq_os, 1, irq_fr, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule